// File: doc/BRIEF.md
# Low-Power Pin Retention Controller

This block keeps a port's pad-control outputs steady across a deep sleep state in which the port's configuration registers are wiped. A sleep-entry request snapshots the pad controls and the wake configuration, sets a retention lock and returns all configuration registers to their defaults. The pads keep showing the snapshot through sleep, through wake-up and through any software reconfiguration. They stay frozen until software writes 0 to the lock.

While asleep, an edge of the frozen polarity on an input that is both wake-capable and wake-enabled ends sleep and leaves that pin's flag set. While the lock is set, software cannot clear flags. After restoring its configuration, software releases the lock. The pads then follow the live registers, and the flag that caused the wake can be serviced and cleared.

Top module: `pin_retain_ctrl`

## Requirements
- R1: A cycle with `sleep_req_i`=1 while awake sets `lock_o` and `asleep_o` at the next edge. If the lock was clear, the pad outputs from then on equal the values they had just before that edge.
- R2: On sleep entry, every configuration register (selects 0..5) and every flag returns to 0.
- R3: While `lock_o`=1, the pad outputs do not change, including after wake-up.
- R4: Configuration writes made while locked and awake are stored and read back on `rd_data_o`, with no effect on the pads.
- R5: A write to select 7 (LOCK) with data bit 0 = 0 while awake clears the lock, and the pads then follow the live registers. Writing bit 0 = 1 has no effect.
- R6: Register writes are ignored while `asleep_o`=1.
- R7: While asleep, a pin wakes the block only if its bit is set in WAKE_MASK and in the frozen interrupt-enable snapshot, and only on the frozen edge polarity. A waking edge sets that pin's flag, and `asleep_o` clears at the same edge. Edges on any other pin have no effect.
- R8: A write to select 6 (FLAG_CLR) clears the flags whose data bits are 1, but only while the lock is clear. While locked it has no effect.
- R9: While awake, a pin's flag is set by a rising edge when its edge-select bit (select 4) is 0, and by a falling edge when that bit is 1.
- R10: `irq_o` is 1 exactly when awake and some flag is set whose interrupt-enable bit (select 5) is 1.
- R11: Live pad mapping:
  - output enable = direction (select 0);
  - output value = output register (select 1);
  - pull enable = pull-enable (select 2) AND NOT direction;
  - pull select = output register;
  - drive strength = drive register (select 3).
  - Register reads use the same selects. Select 6 reads the flags and select 7 reads the lock in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sleep_req_i | input | 1 | Request to enter deep sleep |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register select for writes |
| wr_data_i | input | NUM_PINS | Write data |
| rd_sel_i | input | 3 | Register select for reads |
| rd_data_o | output | NUM_PINS | Read data (combinational) |
| pad_in_i | input | NUM_PINS | Synchronous pin input levels |
| pad_oe_o | output | NUM_PINS | Pad output enable |
| pad_out_o | output | NUM_PINS | Pad output value |
| pad_pe_o | output | NUM_PINS | Pad pull enable |
| pad_ps_o | output | NUM_PINS | Pad pull select (1 = up) |
| pad_ds_o | output | NUM_PINS | Pad drive strength (1 = full) |
| flags_o | output | NUM_PINS | Interrupt flags |
| irq_o | output | 1 | Interrupt request |
| lock_o | output | 1 | Retention lock |
| asleep_o | output | 1 | Deep-sleep state |
| wake_o | output | 1 | Wake event this cycle |

## Verification
The pads are tested with a mixed configuration in which direction, pull and output bits differ per pin. That separates the pull gating from a plain copy of the registers. The snapshot is then confronted with a different register set written while locked, and pad changes are checked against lock release.

Wake is tried with three kinds of edge. An edge on a pin outside the wake mask, an edge of the wrong polarity on a wake-capable pin, and the right edge on an enabled wake pin show that the mask, the frozen polarity and the frozen enable each gate the wake. A second sleep with interrupts disabled shows that the wake enable was captured at entry. Flag clears before and after release tell the lock's blocking from a dead clear path.

// File: rtl/pin_retain_pkg.sv
package pin_retain_pkg;
  typedef enum logic [2:0] {
    SEL_DIR      = 3'd0,
    SEL_OUT      = 3'd1,
    SEL_PULL_EN  = 3'd2,
    SEL_DRIVE    = 3'd3,
    SEL_EDGE     = 3'd4,
    SEL_IRQ_EN   = 3'd5,
    SEL_FLAG_CLR = 3'd6,
    SEL_LOCK     = 3'd7
  } reg_sel_e;

  localparam int unsigned NUM_CFG = 6;
endpackage

// File: rtl/pin_retain_cfg_regs.sv
module pin_retain_cfg_regs
  import pin_retain_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  reg_sel_e            wr_sel_i,
  input  logic [NUM_PINS-1:0] wr_data_i,
  input  logic                block_i,
  input  logic                wipe_i,
  output logic [NUM_PINS-1:0] dir_o,
  output logic [NUM_PINS-1:0] out_o,
  output logic [NUM_PINS-1:0] pull_en_o,
  output logic [NUM_PINS-1:0] drive_o,
  output logic [NUM_PINS-1:0] edge_o,
  output logic [NUM_PINS-1:0] irq_en_o
);
  logic [NUM_PINS-1:0] regs_q [NUM_CFG];

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_reg
    logic hit;
    assign hit = wr_en_i && !block_i && (wr_sel_i == reg_sel_e'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     regs_q[g] <= '0;
      else if (wipe_i) regs_q[g] <= '0;
      else if (hit)    regs_q[g] <= wr_data_i;
    end
  end

  assign dir_o     = regs_q[SEL_DIR];
  assign out_o     = regs_q[SEL_OUT];
  assign pull_en_o = regs_q[SEL_PULL_EN];
  assign drive_o   = regs_q[SEL_DRIVE];
  assign edge_o    = regs_q[SEL_EDGE];
  assign irq_en_o  = regs_q[SEL_IRQ_EN];
endmodule

// File: rtl/pin_retain_pad_hold.sv
module pin_retain_pad_hold #(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                capture_i,
  input  logic                lock_i,
  input  logic [NUM_PINS-1:0] dir_i,
  input  logic [NUM_PINS-1:0] out_i,
  input  logic [NUM_PINS-1:0] pull_en_i,
  input  logic [NUM_PINS-1:0] drive_i,
  input  logic [NUM_PINS-1:0] edge_i,
  input  logic [NUM_PINS-1:0] irq_en_i,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_pe_o,
  output logic [NUM_PINS-1:0] pad_ps_o,
  output logic [NUM_PINS-1:0] pad_ds_o,
  output logic [NUM_PINS-1:0] wake_edge_o,
  output logic [NUM_PINS-1:0] wake_en_o
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic live_oe, live_out, live_pe, live_ps, live_ds;
    logic hold_oe_q, hold_out_q, hold_pe_q, hold_ps_q, hold_ds_q;
    logic hold_edge_q, hold_en_q;

    assign live_oe  = dir_i[p];
    assign live_out = out_i[p];
    assign live_pe  = pull_en_i[p] & ~dir_i[p];
    assign live_ps  = out_i[p];
    assign live_ds  = drive_i[p];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hold_oe_q   <= 1'b0;
        hold_out_q  <= 1'b0;
        hold_pe_q   <= 1'b0;
        hold_ps_q   <= 1'b0;
        hold_ds_q   <= 1'b0;
        hold_edge_q <= 1'b0;
        hold_en_q   <= 1'b0;
      end else if (capture_i) begin
        hold_oe_q   <= live_oe;
        hold_out_q  <= live_out;
        hold_pe_q   <= live_pe;
        hold_ps_q   <= live_ps;
        hold_ds_q   <= live_ds;
        hold_edge_q <= edge_i[p];
        hold_en_q   <= irq_en_i[p];
      end
    end

    assign pad_oe_o[p]    = lock_i ? hold_oe_q  : live_oe;
    assign pad_out_o[p]   = lock_i ? hold_out_q : live_out;
    assign pad_pe_o[p]    = lock_i ? hold_pe_q  : live_pe;
    assign pad_ps_o[p]    = lock_i ? hold_ps_q  : live_ps;
    assign pad_ds_o[p]    = lock_i ? hold_ds_q  : live_ds;
    assign wake_edge_o[p] = hold_edge_q;
    assign wake_en_o[p]   = hold_en_q;
  end
endmodule

// File: rtl/pin_retain_edge_flags.sv
module pin_retain_edge_flags #(
  parameter int unsigned          NUM_PINS  = 8,
  parameter logic [NUM_PINS-1:0]  WAKE_MASK = '1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pad_in_i,
  input  logic                asleep_i,
  input  logic                wipe_i,
  input  logic [NUM_PINS-1:0] live_edge_i,
  input  logic [NUM_PINS-1:0] wake_edge_i,
  input  logic [NUM_PINS-1:0] wake_en_i,
  input  logic                clr_en_i,
  input  logic [NUM_PINS-1:0] clr_mask_i,
  output logic [NUM_PINS-1:0] flags_o,
  output logic                wake_hit_o
);
  logic [NUM_PINS-1:0] prev_q, flags_q, rise, fall, pol, hit, set;

  assign rise = pad_in_i & ~prev_q;
  assign fall = ~pad_in_i & prev_q;
  assign pol  = asleep_i ? wake_edge_i : live_edge_i;
  assign hit  = (rise & ~pol) | (fall & pol);
  // asleep: only wake-capable pins with frozen enable may flag
  assign set  = asleep_i ? (hit & wake_en_i & WAKE_MASK) : hit;
  assign wake_hit_o = asleep_i && (set != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      flags_q <= '0;
    end else begin
      prev_q <= pad_in_i;
      if (wipe_i)        flags_q <= '0;
      else if (clr_en_i) flags_q <= (flags_q & ~clr_mask_i) | set;
      else               flags_q <= flags_q | set;
    end
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/pin_retain_lock_fsm.sv
module pin_retain_lock_fsm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleep_req_i,
  input  logic lock_wr_i,
  input  logic lock_wr_bit_i,
  input  logic wake_hit_i,
  output logic entry_o,
  output logic capture_o,
  output logic lock_o,
  output logic asleep_o
);
  logic lock_q, asleep_q;

  assign entry_o   = sleep_req_i && !asleep_q;
  assign capture_o = entry_o && !lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q   <= 1'b0;
      asleep_q <= 1'b0;
    end else if (entry_o) begin
      lock_q   <= 1'b1;
      asleep_q <= 1'b1;
    end else if (asleep_q) begin
      if (wake_hit_i) asleep_q <= 1'b0;
    end else if (lock_wr_i && !lock_wr_bit_i) begin
      lock_q <= 1'b0;
    end
  end

  assign lock_o   = lock_q;
  assign asleep_o = asleep_q;
endmodule

// File: rtl/pin_retain_ctrl.sv
module pin_retain_ctrl
  import pin_retain_pkg::*;
#(
  parameter int unsigned         NUM_PINS  = 8,
  parameter logic [NUM_PINS-1:0] WAKE_MASK = 8'h03
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sleep_req_i,
  input  logic                wr_en_i,
  input  logic [2:0]          wr_sel_i,
  input  logic [NUM_PINS-1:0] wr_data_i,
  input  logic [2:0]          rd_sel_i,
  output logic [NUM_PINS-1:0] rd_data_o,
  input  logic [NUM_PINS-1:0] pad_in_i,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_pe_o,
  output logic [NUM_PINS-1:0] pad_ps_o,
  output logic [NUM_PINS-1:0] pad_ds_o,
  output logic [NUM_PINS-1:0] flags_o,
  output logic                irq_o,
  output logic                lock_o,
  output logic                asleep_o,
  output logic                wake_o
);
  reg_sel_e wsel, rsel;
  logic [NUM_PINS-1:0] cfg_dir, cfg_out, cfg_pull_en, cfg_drive, cfg_edge, cfg_irq_en;
  logic [NUM_PINS-1:0] wake_edge, wake_en;
  logic sleep_entry, capture, wake_hit, clr_en, lock_wr;

  assign wsel = reg_sel_e'(wr_sel_i);
  assign rsel = reg_sel_e'(rd_sel_i);

  assign lock_wr = wr_en_i && (wsel == SEL_LOCK);
  assign clr_en  = wr_en_i && (wsel == SEL_FLAG_CLR) && !asleep_o && !lock_o;

  pin_retain_lock_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .sleep_req_i   (sleep_req_i),
    .lock_wr_i     (lock_wr),
    .lock_wr_bit_i (wr_data_i[0]),
    .wake_hit_i    (wake_hit),
    .entry_o       (sleep_entry),
    .capture_o     (capture),
    .lock_o        (lock_o),
    .asleep_o      (asleep_o)
  );

  pin_retain_cfg_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wsel),
    .wr_data_i (wr_data_i),
    .block_i   (asleep_o),
    .wipe_i    (sleep_entry),
    .dir_o     (cfg_dir),
    .out_o     (cfg_out),
    .pull_en_o (cfg_pull_en),
    .drive_o   (cfg_drive),
    .edge_o    (cfg_edge),
    .irq_en_o  (cfg_irq_en)
  );

  pin_retain_pad_hold #(.NUM_PINS(NUM_PINS)) u_hold (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .capture_i   (capture),
    .lock_i      (lock_o),
    .dir_i       (cfg_dir),
    .out_i       (cfg_out),
    .pull_en_i   (cfg_pull_en),
    .drive_i     (cfg_drive),
    .edge_i      (cfg_edge),
    .irq_en_i    (cfg_irq_en),
    .pad_oe_o    (pad_oe_o),
    .pad_out_o   (pad_out_o),
    .pad_pe_o    (pad_pe_o),
    .pad_ps_o    (pad_ps_o),
    .pad_ds_o    (pad_ds_o),
    .wake_edge_o (wake_edge),
    .wake_en_o   (wake_en)
  );

  pin_retain_edge_flags #(.NUM_PINS(NUM_PINS), .WAKE_MASK(WAKE_MASK)) u_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pad_in_i    (pad_in_i),
    .asleep_i    (asleep_o),
    .wipe_i      (sleep_entry),
    .live_edge_i (cfg_edge),
    .wake_edge_i (wake_edge),
    .wake_en_i   (wake_en),
    .clr_en_i    (clr_en),
    .clr_mask_i  (wr_data_i),
    .flags_o     (flags_o),
    .wake_hit_o  (wake_hit)
  );

  assign wake_o = wake_hit;
  assign irq_o  = !asleep_o && ((flags_o & cfg_irq_en) != '0);

  always_comb begin
    unique case (rsel)
      SEL_DIR:      rd_data_o = cfg_dir;
      SEL_OUT:      rd_data_o = cfg_out;
      SEL_PULL_EN:  rd_data_o = cfg_pull_en;
      SEL_DRIVE:    rd_data_o = cfg_drive;
      SEL_EDGE:     rd_data_o = cfg_edge;
      SEL_IRQ_EN:   rd_data_o = cfg_irq_en;
      SEL_FLAG_CLR: rd_data_o = flags_o;
      SEL_LOCK:     rd_data_o = {{(NUM_PINS-1){1'b0}}, lock_o};
      default:      rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/pin_retain_ctrl_chk.sv
module pin_retain_ctrl_chk #(
  parameter int unsigned NUM_PINS = 8
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  sleep_entry_i,
  input logic                  lock_i,
  input logic                  asleep_i,
  input logic                  wake_i,
  input logic                  irq_i,
  input logic [NUM_PINS-1:0]   flags_i,
  input logic [5*NUM_PINS-1:0] pads_i,
  input logic [6*NUM_PINS-1:0] cfg_i
);
  p_enter_lock_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_entry_i |=> (lock_i && asleep_i));

  p_cfg_default_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_entry_i |=> (cfg_i == '0 && flags_i == '0));

  p_pads_frozen_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(lock_i) && lock_i) |-> $stable(pads_i));

  p_wake_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_i |=> (!asleep_i && flags_i != '0));

  p_no_clear_locked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_i && !sleep_entry_i) |=> ((flags_i & $past(flags_i)) == $past(flags_i)));

  p_no_irq_asleep_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    asleep_i |-> !irq_i);
endmodule

bind pin_retain_ctrl pin_retain_ctrl_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .sleep_entry_i (sleep_entry),
  .lock_i        (lock_o),
  .asleep_i      (asleep_o),
  .wake_i        (wake_o),
  .irq_i         (irq_o),
  .flags_i       (flags_o),
  .pads_i        ({pad_oe_o, pad_out_o, pad_pe_o, pad_ps_o, pad_ds_o}),
  .cfg_i         ({cfg_dir, cfg_out, cfg_pull_en, cfg_drive, cfg_edge, cfg_irq_en})
);

// File: tb/pin_retain_ctrl_tb_top.sv
module pin_retain_ctrl_tb_top;
  localparam int N = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         sleep_req_i = 1'b0;
  logic         wr_en_i = 1'b0;
  logic [2:0]   wr_sel_i = '0;
  logic [N-1:0] wr_data_i = '0;
  logic [2:0]   rd_sel_i = '0;
  logic [N-1:0] rd_data_o;
  logic [N-1:0] pad_in_i = '0;
  logic [N-1:0] pad_oe_o, pad_out_o, pad_pe_o, pad_ps_o, pad_ds_o, flags_o;
  logic         irq_o, lock_o, asleep_o, wake_o;

  always #2 clk_i = ~clk_i;

  pin_retain_ctrl #(.NUM_PINS(N), .WAKE_MASK(8'h03)) dut_i (.*);

  typedef enum int {K_PADS, K_FLAGS, K_LOCK, K_ASLEEP, K_IRQ, K_RD} kind_e;
  typedef struct {
    kind_e       kind;
    string       req;
    logic [63:0] exp;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  function automatic logic [63:0] observe(kind_e k);
    case (k)
      K_PADS:   return 64'({pad_oe_o, pad_out_o, pad_pe_o, pad_ps_o, pad_ds_o});
      K_FLAGS:  return 64'(flags_o);
      K_LOCK:   return 64'(lock_o);
      K_ASLEEP: return 64'(asleep_o);
      K_IRQ:    return 64'(irq_o);
      default:  return 64'(rd_data_o);
    endcase
  endfunction

  function automatic logic [63:0] pads(logic [7:0] oe, logic [7:0] o, logic [7:0] pe,
                                       logic [7:0] ps, logic [7:0] ds);
    return 64'({oe, o, pe, ps, ds});
  endfunction

  // monitor: pops expectations and compares against the live outputs
  initial begin
    forever begin
      item_t it;
      logic [63:0] act;
      wait (q.size() != 0);
      it = q.pop_front();
      act = observe(it.kind);
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic expect_item(kind_e k, string req, logic [63:0] e);
    item_t it;
    it.kind = k; it.req = req; it.exp = e;
    q.push_back(it);
    #1;
  endtask

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic wr(logic [2:0] sel, logic [N-1:0] d);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
    tick();
    wr_en_i = 1'b0;
  endtask

  task automatic rd_chk(logic [2:0] sel, string req, logic [N-1:0] e);
    rd_sel_i = sel;
    #1;
    expect_item(K_RD, req, 64'(e));
  endtask

  task automatic pin(logic [N-1:0] v);
    pad_in_i = v;
    tick();
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    tick();
    // reset state
    expect_item(K_LOCK,   "RST lock", 0);
    expect_item(K_ASLEEP, "RST asleep", 0);
    expect_item(K_PADS,   "RST pads", 0);
    expect_item(K_FLAGS,  "RST flags", 0);

    // R11 live mapping
    wr(3'd0, 8'h0F); wr(3'd1, 8'h35); wr(3'd2, 8'hF0);
    wr(3'd3, 8'h0C); wr(3'd4, 8'h02); wr(3'd5, 8'h03);
    expect_item(K_PADS, "R11 live pads", pads(8'h0F, 8'h35, 8'hF0, 8'h35, 8'h0C));
    rd_chk(3'd4, "R11 read edge", 8'h02);

    // R9 edge polarity
    pin(8'h01);
    expect_item(K_FLAGS, "R9 rise sel0", 64'h01);
    pin(8'h03);
    expect_item(K_FLAGS, "R9 rise ignored sel1", 64'h01);
    pin(8'h01);
    expect_item(K_FLAGS, "R9 fall sel1", 64'h03);
    expect_item(K_IRQ, "R10 irq enabled", 1);
    wr(3'd6, 8'h03);
    expect_item(K_FLAGS, "R8 clear unlocked", 0);
    expect_item(K_IRQ, "R10 irq cleared", 0);
    pin(8'h05);
    expect_item(K_FLAGS, "R9 pin2 rise", 64'h04);
    expect_item(K_IRQ, "R10 disabled pin no irq", 0);
    wr(3'd6, 8'h04);
    pin(8'h00);
    expect_item(K_FLAGS, "R9 falls ignored sel0", 0);

    // R1/R2 sleep entry
    sleep_req_i = 1'b1; tick(); sleep_req_i = 1'b0;
    expect_item(K_LOCK,   "R1 lock set", 1);
    expect_item(K_ASLEEP, "R1 asleep", 1);
    expect_item(K_PADS,   "R1 pads captured", pads(8'h0F, 8'h35, 8'hF0, 8'h35, 8'h0C));
    rd_chk(3'd0, "R2 dir default", 0);
    rd_chk(3'd5, "R2 irq_en default", 0);
    expect_item(K_FLAGS, "R2 flags cleared", 0);

    // R6 writes ignored asleep
    wr(3'd0, 8'hFF);
    rd_chk(3'd0, "R6 write ignored asleep", 0);
    wr(3'd7, 8'h00);
    expect_item(K_LOCK, "R6 lock write ignored asleep", 1);

    // R7 wake gating
    pin(8'h04);
    expect_item(K_ASLEEP, "R7 non-wake pin", 1);
    pin(8'h06);
    expect_item(K_ASLEEP, "R7 wrong polarity", 1);
    expect_item(K_FLAGS, "R7 no flag", 0);
    pin(8'h07);
    expect_item(K_ASLEEP, "R7 woke", 0);
    expect_item(K_FLAGS, "R7 wake flag", 64'h01);
    expect_item(K_PADS, "R3 frozen after wake", pads(8'h0F, 8'h35, 8'hF0, 8'h35, 8'h0C));

    // R4 writes while locked
    wr(3'd0, 8'hAA); wr(3'd1, 8'h55);
    rd_chk(3'd0, "R4 dir stored", 8'hAA);
    expect_item(K_PADS, "R4 pads unaffected", pads(8'h0F, 8'h35, 8'hF0, 8'h35, 8'h0C));

    // R8 clear blocked while locked
    wr(3'd6, 8'hFF);
    expect_item(K_FLAGS, "R8 clear blocked", 64'h01);

    // R5 release
    wr(3'd7, 8'h01);
    expect_item(K_LOCK, "R5 write 1 no effect", 1);
    wr(3'd7, 8'h00);
    expect_item(K_LOCK, "R5 released", 0);
    rd_chk(3'd7, "R5 lock readback", 0);
    expect_item(K_PADS, "R5 pads live", pads(8'hAA, 8'h55, 8'h00, 8'h55, 8'h00));
    wr(3'd6, 8'h01);
    expect_item(K_FLAGS, "R8 clear after release", 0);

    // second sleep with wake disabled in snapshot
    sleep_req_i = 1'b1; tick(); sleep_req_i = 1'b0;
    pin(8'h06);
    pin(8'h07);
    expect_item(K_ASLEEP, "R7 frozen enable off", 1);
    expect_item(K_FLAGS,  "R7 no flag disabled", 0);
    expect_item(K_IRQ,    "R10 no irq asleep", 0);
    expect_item(K_PADS,   "R3 second snapshot", pads(8'hAA, 8'h55, 8'h00, 8'h55, 8'h00));

    tick();
    wait (q.size() == 0);
    #1;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule